// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block gathers eight peripheral interrupt request lines, holds each request until the processor takes it, and picks a winner by fixed priority. Line 0 ranks highest and line 7 lowest. When an eligible request exists, the block raises a single interrupt output to the processor. The processor answers with a one-cycle acknowledge pulse. On that pulse the block moves the winning line from pending to in service. One cycle later it presents an 8-bit vector byte with a valid strobe.

The block keeps one in-service flag per line, which lets service routines nest. A request can interrupt the processor only if no line of the same or higher priority is in service. Software finishes a routine with an end-of-interrupt pulse, which retires the highest-priority in-service level. Lower levels then become eligible again.

A per-line mask holds a line back from being granted without losing its pending request. In cascade mode, line 2 belongs to a second controller of the same kind. Acknowledging that line takes the vector byte from the second controller and pulses an acknowledge toward it. This gives fifteen usable request lines.

Top module: `pvic_top`

## Requirements
- R1: After reset the interrupt output and the vector valid strobe are low, and no line is pending or in service.
- R2: A request input that is high at a clock edge is held pending until acknowledged. A one-cycle pulse on an unmasked line with nothing in service raises the interrupt output from the next cycle on, and it stays high until acknowledged.
- R3: On acknowledge, the granted line is the pending, unmasked and eligible line with the lowest index (line 0 highest priority). At most one line is granted per acknowledge.
- R4: The vector byte is the 5-bit programmed base in bits 7:3 and the granted line number in bits 2:0. It is valid for exactly one cycle, in the cycle after the acknowledge edge.
- R5: Acknowledging line k clears its pending bit and sets its in-service bit. With no other eligible request, the interrupt output is low from the next cycle.
- R6: While line k is in service, a request on a line j < k raises the interrupt output, and a request on any line j ≥ k does not.
- R7: An end-of-interrupt pulse clears the in-service bit with the lowest index. Pending lower-priority requests that this unblocks raise the interrupt output from the next cycle.
- R8: A masked line (mask bit = 1) is never granted and does not raise the interrupt output, but stays pending. Clearing its mask bit makes it eligible from the cycle after the write.
- R9: With cascade enabled, granting line 2 gives the slave vector input sampled at the acknowledge edge as the vector, and pulses the slave acknowledge together with the valid strobe. With cascade disabled, line 2 gets the base-plus-line vector and the slave acknowledge stays low.
- R10: An acknowledge while no request is eligible produces no valid strobe and changes no pending or in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Request inputs, sampled each edge |
| mask_we | input | 1 | Load the mask register |
| mask_wdata | input | 8 | New mask, 1 = line held back |
| base_we | input | 1 | Load the vector base |
| base_wdata | input | 5 | New vector base |
| cascade_en | input | 1 | Line 2 is served by a slave controller |
| slave_vec | input | 8 | Vector byte from the slave controller |
| inta | input | 1 | Processor acknowledge pulse |
| eoi | input | 1 | End-of-interrupt pulse |
| intr | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector byte |
| vec_valid | output | 1 | Vector byte valid, one cycle |
| slave_ack | output | 1 | Acknowledge forwarded to the slave |

## Verification
A stale pending bit shows up as the interrupt output staying high after the acknowledge, or rising again with no new request, one cycle after the faulty edge. A wrong in-service set appears in two ways: pre-emption that should not happen, or a missing interrupt after an end-of-interrupt, both in the cycle after the command. A priority or cascade slip shows up as a wrong vector byte on the very next valid strobe. Because the bench model is compared every cycle, each of these shows up within one clock of the bad state update.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int PVIC_LINES = 8;
  localparam int PVIC_IDX_W = $clog2(PVIC_LINES);

  typedef logic [PVIC_LINES-1:0] line_vec_t;

  // lines that may still interrupt: no same-or-higher level in service
  function automatic line_vec_t eligible_levels(line_vec_t isr);
    line_vec_t r;
    logic      blocked;
    r       = '0;
    blocked = 1'b0;
    for (int i = 0; i < PVIC_LINES; i++) begin
      if (isr[i]) blocked = 1'b1;
      r[i] = ~blocked;
    end
    return r;
  endfunction

  // keep only the lowest-index set bit
  function automatic line_vec_t pick_first(line_vec_t v);
    line_vec_t r;
    logic      found;
    r     = '0;
    found = 1'b0;
    for (int i = 0; i < PVIC_LINES; i++) begin
      if (v[i] && !found) begin
        r[i]  = 1'b1;
        found = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [PVIC_IDX_W-1:0] onehot_index(line_vec_t v);
    logic [PVIC_IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < PVIC_LINES; i++) begin
      if (v[i]) r = PVIC_IDX_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/pvic_req_latch.sv
module pvic_req_latch
  import pvic_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t irq_in,
  input  line_vec_t clr,
  output line_vec_t irr
);
  line_vec_t irr_next;

  always_comb irr_next = (irr | irq_in) & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irr <= '0;
    else        irr <= irr_next;
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(irr) & ~$past(clr)) & ~irr) == '0); // R2
endmodule

// File: rtl/pvic_resolver.sv
module pvic_resolver
  import pvic_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  line_vec_t             irr,
  input  line_vec_t             mask,
  input  line_vec_t             isr,
  output logic                  cand_any,
  output line_vec_t             win_onehot,
  output logic [PVIC_IDX_W-1:0] win_idx
);
  line_vec_t cand;

  always_comb begin
    cand       = irr & ~mask & eligible_levels(isr);
    win_onehot = pick_first(cand);
    win_idx    = onehot_index(win_onehot);
    cand_any   = |cand;
  end

  AST_NO_MASKED_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (win_onehot & mask) == '0); // R8
  AST_PREEMPT_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_any && isr != '0) |-> (win_onehot < (isr & (~isr + 1'b1)))); // R6
endmodule

// File: rtl/pvic_inservice.sv
module pvic_inservice
  import pvic_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t ack_set,
  input  logic      eoi,
  output line_vec_t isr
);
  line_vec_t eoi_clr;

  always_comb eoi_clr = eoi ? pick_first(isr) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr <= '0;
    else        isr <= (isr & ~eoi_clr) | ack_set;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_set)); // R3
  AST_EOI_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && isr != '0 && ack_set == '0) |=>
      ($countones(isr) == $countones($past(isr)) - 1)); // R7
endmodule

// File: rtl/pvic_vector.sv
module pvic_vector
  import pvic_pkg::*;
#(
  parameter int VEC_W        = 8,
  parameter int CASCADE_LINE = 2,
  localparam int BASE_W      = VEC_W - PVIC_IDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  inta,
  input  logic                  fire,
  input  logic [PVIC_IDX_W-1:0] win_idx,
  input  logic [BASE_W-1:0]     base,
  input  logic                  cascade_en,
  input  logic [VEC_W-1:0]      slave_vec,
  output logic [VEC_W-1:0]      vec_out,
  output logic                  vec_valid,
  output logic                  slave_ack
);
  logic to_slave;

  always_comb to_slave = cascade_en && (win_idx == PVIC_IDX_W'(CASCADE_LINE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_out   <= '0;
      vec_valid <= 1'b0;
      slave_ack <= 1'b0;
    end else begin
      vec_valid <= fire;
      slave_ack <= fire && to_slave;
      if (fire) vec_out <= to_slave ? slave_vec : {base, win_idx};
    end
  end

  AST_VALID_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(inta)); // R4
  AST_SLAVE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    slave_ack |-> vec_valid); // R9
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int VEC_W        = 8,
  parameter int CASCADE_LINE = 2,
  localparam int BASE_W      = VEC_W - PVIC_IDX_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PVIC_LINES-1:0] irq_in,
  input  logic                  mask_we,
  input  logic [PVIC_LINES-1:0] mask_wdata,
  input  logic                  base_we,
  input  logic [BASE_W-1:0]     base_wdata,
  input  logic                  cascade_en,
  input  logic [VEC_W-1:0]      slave_vec,
  input  logic                  inta,
  input  logic                  eoi,
  output logic                  intr,
  output logic [VEC_W-1:0]      vec_out,
  output logic                  vec_valid,
  output logic                  slave_ack
);
  line_vec_t             irr, isr, mask_q, win_onehot, ack_set;
  logic                  cand_any, ack_fire;
  logic [PVIC_IDX_W-1:0] win_idx;
  logic [BASE_W-1:0]     base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      base_q <= '0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      if (base_we) base_q <= base_wdata;
    end
  end

  always_comb begin
    ack_fire = inta && cand_any;
    ack_set  = ack_fire ? win_onehot : '0;
    intr     = cand_any;
  end

  pvic_req_latch u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr(ack_set), .irr(irr));

  pvic_resolver u_res (
    .clk(clk), .rst_n(rst_n), .irr(irr), .mask(mask_q), .isr(isr),
    .cand_any(cand_any), .win_onehot(win_onehot), .win_idx(win_idx));

  pvic_inservice u_isr (
    .clk(clk), .rst_n(rst_n), .ack_set(ack_set), .eoi(eoi), .isr(isr));

  pvic_vector #(.VEC_W(VEC_W), .CASCADE_LINE(CASCADE_LINE)) u_vec (
    .clk(clk), .rst_n(rst_n), .inta(inta), .fire(ack_fire), .win_idx(win_idx),
    .base(base_q), .cascade_en(cascade_en), .slave_vec(slave_vec),
    .vec_out(vec_out), .vec_valid(vec_valid), .slave_ack(slave_ack));

  AST_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !intr) |=> !vec_valid); // R10
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!intr && !vec_valid)); // R1
endmodule

// File: tb/pvic_top_test.sv
module pvic_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0, mask_wdata = '0, slave_vec = '0;
  logic       mask_we = 1'b0, base_we = 1'b0, cascade_en = 1'b0;
  logic [4:0] base_wdata = '0;
  logic       inta = 1'b0, eoi = 1'b0;
  logic       intr, vec_valid, slave_ack;
  logic [7:0] vec_out;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  bit m_irr[8], m_isr[8], m_mask[8];
  int m_base, m_vec;
  bit m_vv, m_sack;

  always #4 clk = ~clk;

  pvic_top uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .base_we(base_we), .base_wdata(base_wdata),
    .cascade_en(cascade_en), .slave_vec(slave_vec), .inta(inta), .eoi(eoi),
    .intr(intr), .vec_out(vec_out), .vec_valid(vec_valid), .slave_ack(slave_ack));

  function automatic int m_winner();
    int top = 8;
    for (int i = 7; i >= 0; i--) if (m_isr[i]) top = i;
    for (int i = 0; i < 8; i++)
      if (i < top && m_irr[i] && !m_mask[i]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_irr[i] = 0; m_isr[i] = 0; m_mask[i] = 0; end
      m_base = 0; m_vec = 0; m_vv = 0; m_sack = 0;
    end else begin
      int w, e;
      bit ack;
      w = m_winner();
      ack = inta && (w >= 0);
      e = -1;
      if (eoi) for (int i = 7; i >= 0; i--) if (m_isr[i]) e = i;
      if (e >= 0) m_isr[e] = 0;
      m_vv = ack;
      m_sack = ack && cascade_en && (w == 2);
      if (ack) begin
        m_isr[w] = 1;
        m_vec = m_sack ? int'(slave_vec) : (m_base * 8 + w);
      end
      for (int i = 0; i < 8; i++) m_irr[i] = m_irr[i] | irq_in[i];
      if (ack) m_irr[w] = 0;
      if (mask_we) for (int i = 0; i < 8; i++) m_mask[i] = mask_wdata[i];
      if (base_we) m_base = int'(base_wdata);
    end
  end

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 model intr", int'(intr), int'(m_winner() >= 0));
      chk("R4 model valid", int'(vec_valid), int'(m_vv));
      if (m_vv) chk("R4 model vector", int'(vec_out), m_vec);
      chk("R9 model slave_ack", int'(slave_ack), int'(m_sack));
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected finish");
      report();
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse_irq(logic [7:0] v);
    irq_in = v; tick(); irq_in = '0;
  endtask

  task automatic do_ack();
    inta = 1'b1; tick(); inta = 1'b0;
  endtask

  task automatic do_eoi();
    eoi = 1'b1; tick(); eoi = 1'b0;
  endtask

  task automatic set_mask(logic [7:0] v);
    mask_we = 1'b1; mask_wdata = v; tick(); mask_we = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    chk("R1 reset intr", int'(intr), 0);
    chk("R1 reset valid", int'(vec_valid), 0);
    tick();
    rst_n = 1'b1;
    tick();
    chk("R1 idle intr", int'(intr), 0);
    base_we = 1'b1; base_wdata = 5'h15; tick(); base_we = 1'b0;

    pulse_irq(8'h20);
    chk("R2 intr after pulse", int'(intr), 1);
    tick(); tick();
    chk("R2 intr held", int'(intr), 1);
    do_ack();
    chk("R4 valid", int'(vec_valid), 1);
    chk("R4 vector line5", int'(vec_out), 8'hAD);
    chk("R5 intr drops", int'(intr), 0);
    tick();
    chk("R4 valid one cycle", int'(vec_valid), 0);

    pulse_irq(8'h40);
    chk("R6 lower blocked", int'(intr), 0);
    pulse_irq(8'h20);
    chk("R6 equal blocked", int'(intr), 0);
    pulse_irq(8'h08);
    chk("R6 higher preempts", int'(intr), 1);
    do_ack();
    chk("R3 vector line3", int'(vec_out), 8'hAB);
    do_eoi();
    chk("R7 still blocked", int'(intr), 0);
    do_eoi();
    chk("R7 unblocked", int'(intr), 1);
    do_ack();
    chk("R3 vector line5 again", int'(vec_out), 8'hAD);
    do_eoi();
    do_ack();
    chk("R3 vector line6", int'(vec_out), 8'hAE);
    do_eoi();

    pulse_irq(8'h90);
    do_ack();
    chk("R3 line4 beats line7", int'(vec_out), 8'hAC);
    do_eoi();
    do_ack();
    chk("R3 then line7", int'(vec_out), 8'hAF);
    do_eoi();

    set_mask(8'h02);
    pulse_irq(8'h02);
    chk("R8 masked no intr", int'(intr), 0);
    do_ack();
    chk("R10 spurious no valid", int'(vec_valid), 0);
    set_mask(8'h00);
    chk("R8 unmask raises intr", int'(intr), 1);
    do_ack();
    chk("R8 pending kept", int'(vec_out), 8'hA9);
    do_eoi();
    chk("R10 nothing left", int'(intr), 0);

    cascade_en = 1'b1; slave_vec = 8'h57;
    pulse_irq(8'h04);
    do_ack();
    chk("R9 slave vector", int'(vec_out), 8'h57);
    chk("R9 slave ack", int'(slave_ack), 1);
    do_eoi();
    cascade_en = 1'b0;
    pulse_irq(8'h04);
    do_ack();
    chk("R9 no cascade vector", int'(vec_out), 8'hAA);
    chk("R9 no slave ack", int'(slave_ack), 0);
    do_eoi();

    for (int k = 0; k < 2000; k++) begin
      irq_in     = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
      inta       = (($urandom % 3) == 0);
      eoi        = (($urandom % 5) == 0);
      mask_we    = (($urandom % 29) == 0);
      mask_wdata = 8'($urandom) & 8'h5A;
      base_we    = (($urandom % 41) == 0);
      base_wdata = 5'($urandom);
      cascade_en = (($urandom % 97) == 0) ? ~cascade_en : cascade_en;
      slave_vec  = 8'($urandom);
      tick();
    end
    irq_in = '0; inta = 1'b0; eoi = 1'b0; mask_we = 1'b0; base_we = 1'b0;
    tick();
    done = 1;
    report();
  end
endmodule